// File: doc/BRIEF.md
# Vector Memory Element-Width and Group-Multiplier Legality Checker

This block sits in the decode path of a vector unit's load and store instructions. For each request it takes the instruction's extended-memory bit and 3-bit width field, together with the current element width (SEW) and register group multiplier (LMUL) from the vector configuration. It returns the effective element width (EEW) and the effective group multiplier (EMUL) of the memory operand. It also returns a flag that marks the instruction illegal when that combination cannot be encoded. All widths are carried as log2 values. LMUL is a signed log2, so fractional groupings of 1/2, 1/4 and 1/8 are covered.

Requests enter and results leave on valid/ready streams. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. A result transfers on an edge where `rsp_valid` and `rsp_ready` are both high. With the default registered stage, `req_ready` is high whenever the output register is empty or is being drained in the same cycle. A downstream stall therefore stalls the input at once and drops no request. While a result waits, it is held unchanged. The configuration pins are plain levels sampled together with the request.

Top module: `vmem_eew_chk`

## Requirements
- R1: With the extended-memory bit at 0, EEW is 8 bits (eew_log2 = 3) for width codes 0 and 4. Width codes 5, 6 and 7 give eew_log2 values 4, 5 and 6.
- R2: With the extended-memory bit at 1, the base is 128 bits (log2 7). EEW is the base for width 0 and the base shifted left by (width − 4) for widths 4 to 7. Any EEW whose log2 exceeds ELEN_LOG2 (default 6) is illegal, so at default settings every request with this bit at 1 is illegal.
- R3: Width codes 1, 2 and 3 would need a negative shift and are always illegal.
- R4: emul_log2 = eew_log2 − sew_log2 + lmul_log2. The result is legal only within −3 to +3. emul_log2 is a 3-bit two's complement output, for example 101b = −3.
- R5: The request is illegal when any of the following holds: `cfg_vill` is 1, `cfg_lmul_log2` is the reserved code 100b (−4), or `cfg_sew_log2` lies outside 3 to ELEN_LOG2.
- R6: An illegal result drives `rsp_eew_log2` and `rsp_emul_log2` to zero.
- R7: A result is presented with `rsp_valid` high on the cycle after its request transfers. While `rsp_valid` is high and `rsp_ready` is low, the result stays stable and `req_ready` is low. Raising `rsp_ready` lets a new request transfer on the same edge that the waiting result leaves.
- R8: During and right after reset, `rsp_valid` is 0 and `req_ready` is 1.
- R9: For every legal result, eew_log2 − emul_log2 equals sew_log2 − lmul_log2, so the EEW/EMUL ratio matches the SEW/LMUL ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request stream valid |
| req_ready | output | 1 | Request stream ready |
| req_mew | input | 1 | Extended-memory bit of the instruction |
| req_width | input | 3 | Width field of the instruction |
| cfg_sew_log2 | input | 3 | log2 of SEW in bits |
| cfg_lmul_log2 | input | 3 | Signed log2 of LMUL |
| cfg_vill | input | 1 | Vector configuration already illegal |
| rsp_valid | output | 1 | Result stream valid |
| rsp_ready | input | 1 | Result stream ready |
| rsp_illegal | output | 1 | Illegal-instruction flag |
| rsp_eew_log2 | output | 4 | log2 of EEW in bits |
| rsp_emul_log2 | output | 3 | Signed log2 of EMUL |

## Verification
Every result is due exactly one clock edge after its request transfers. The bench therefore drives each request on a falling edge and reads the result on the next falling edge, after the single register stage has loaded. In the stall test, `rsp_ready` is held low for several cycles. The bench checks the waiting result and `req_ready` on each of those falling edges. It then expects the next result one edge after `rsp_ready` rises. For the reset test, `rsp_valid` is sampled on the falling edge after reset is applied, with no latency in between.

// File: rtl/vmchk_pkg.sv
package vmchk_pkg;
  localparam int EEW_W  = 4;
  localparam int EMUL_W = 3;
  localparam int SEW_W  = 3;
  localparam int LMUL_W = 3;
  localparam int SUM_W  = 6;

  typedef struct packed {
    logic                     illegal;
    logic [EEW_W-1:0]         eew_log2;
    logic signed [EMUL_W-1:0] emul_log2;
  } vmchk_res_t;

  localparam int RES_W = $bits(vmchk_res_t);
endpackage

// File: rtl/vmchk_eew_dec.sv
module vmchk_eew_dec
  import vmchk_pkg::*;
#(
  parameter int ELEN_LOG2 = 6
) (
  input  logic             mew,
  input  logic [2:0]       width,
  output logic [EEW_W-1:0] eew_log2,
  output logic             eew_bad
);
  localparam logic [EEW_W-1:0] BASE_LO  = 4'd3;
  localparam logic [EEW_W-1:0] BASE_HI  = 4'd7;
  localparam logic [EEW_W-1:0] ELEN_LIM = EEW_W'(ELEN_LOG2);

  logic [EEW_W-1:0] base;
  logic [EEW_W-1:0] shifted;

  always_comb begin
    base    = mew ? BASE_HI : BASE_LO;
    shifted = base + {2'b00, width[1:0]};
    eew_log2 = '0;
    eew_bad  = 1'b0;
    if (width == 3'd0) begin
      eew_log2 = base;
    end else if (!width[2]) begin
      eew_bad = 1'b1;
    end else begin
      eew_log2 = shifted;
    end
    if (eew_log2 > ELEN_LIM) eew_bad = 1'b1;
  end
endmodule

// File: rtl/vmchk_emul_calc.sv
module vmchk_emul_calc
  import vmchk_pkg::*;
#(
  parameter int MIN_EMUL_LOG2 = -3,
  parameter int MAX_EMUL_LOG2 = 3
) (
  input  logic [EEW_W-1:0]         eew_log2,
  input  logic [SEW_W-1:0]         sew_log2,
  input  logic signed [LMUL_W-1:0] lmul_log2,
  output logic signed [EMUL_W-1:0] emul_log2,
  output logic                     range_bad
);
  localparam logic signed [SUM_W-1:0] LO_S = SUM_W'(MIN_EMUL_LOG2);
  localparam logic signed [SUM_W-1:0] HI_S = SUM_W'(MAX_EMUL_LOG2);

  logic signed [SUM_W-1:0] sum;

  always_comb begin
    sum = $signed({2'b00, eew_log2})
        - $signed({3'b000, sew_log2})
        + $signed({{(SUM_W-LMUL_W){lmul_log2[LMUL_W-1]}}, lmul_log2});
    range_bad = (sum > HI_S) || (sum < LO_S);
    emul_log2 = sum[EMUL_W-1:0];
  end
endmodule

// File: rtl/vmchk_out_stage.sv
module vmchk_out_stage #(
  parameter int DW         = 8,
  parameter bit REGISTERED = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  generate
    if (REGISTERED) begin : g_reg
      logic          vld_q;
      logic [DW-1:0] dat_q;
      logic          take;

      assign in_ready  = !vld_q || out_ready;
      assign take      = in_valid && in_ready;
      assign out_valid = vld_q;
      assign out_data  = dat_q;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          vld_q <= 1'b0;
          dat_q <= '0;
        end else begin
          if (take) begin
            vld_q <= 1'b1;
            dat_q <= in_data;
          end else if (out_ready) begin
            vld_q <= 1'b0;
          end
        end
      end

      AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R7
    end else begin : g_pass
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign out_data  = in_data;
    end
  endgenerate
endmodule

// File: rtl/vmem_eew_chk.sv
module vmem_eew_chk
  import vmchk_pkg::*;
#(
  parameter int ELEN_LOG2     = 6,
  parameter int MIN_EMUL_LOG2 = -3,
  parameter int MAX_EMUL_LOG2 = 3,
  parameter bit REGISTERED    = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_mew,
  input  logic [2:0]               req_width,
  input  logic [SEW_W-1:0]         cfg_sew_log2,
  input  logic signed [LMUL_W-1:0] cfg_lmul_log2,
  input  logic                     cfg_vill,
  output logic                     rsp_valid,
  input  logic                     rsp_ready,
  output logic                     rsp_illegal,
  output logic [EEW_W-1:0]         rsp_eew_log2,
  output logic signed [EMUL_W-1:0] rsp_emul_log2
);
  localparam logic [SEW_W-1:0]  SEW_MIN   = 3'd3;
  localparam logic [SEW_W-1:0]  SEW_MAX   = SEW_W'(ELEN_LOG2);
  localparam logic [LMUL_W-1:0] LMUL_RSVD = 3'b100;
  localparam logic [EEW_W-1:0]  ELEN_LIM  = EEW_W'(ELEN_LOG2);

  logic [EEW_W-1:0]         eew_raw;
  logic                     eew_bad;
  logic signed [EMUL_W-1:0] emul_raw;
  logic                     range_bad;
  logic                     cfg_bad;
  vmchk_res_t               res_d;
  vmchk_res_t               res_q;

  vmchk_eew_dec #(.ELEN_LOG2(ELEN_LOG2)) eew_i (
    .mew      (req_mew),
    .width    (req_width),
    .eew_log2 (eew_raw),
    .eew_bad  (eew_bad)
  );

  vmchk_emul_calc #(
    .MIN_EMUL_LOG2(MIN_EMUL_LOG2),
    .MAX_EMUL_LOG2(MAX_EMUL_LOG2)
  ) emul_i (
    .eew_log2  (eew_raw),
    .sew_log2  (cfg_sew_log2),
    .lmul_log2 (cfg_lmul_log2),
    .emul_log2 (emul_raw),
    .range_bad (range_bad)
  );

  always_comb begin
    cfg_bad = cfg_vill
           || (cfg_lmul_log2 == LMUL_RSVD)
           || (cfg_sew_log2 < SEW_MIN)
           || (cfg_sew_log2 > SEW_MAX);
    res_d.illegal   = cfg_bad || eew_bad || range_bad;
    res_d.eew_log2  = res_d.illegal ? '0 : eew_raw;
    res_d.emul_log2 = res_d.illegal ? '0 : emul_raw;
  end

  vmchk_out_stage #(.DW(RES_W), .REGISTERED(REGISTERED)) out_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_data   (res_d),
    .out_valid (rsp_valid),
    .out_ready (rsp_ready),
    .out_data  (res_q)
  );

  assign rsp_illegal   = res_q.illegal;
  assign rsp_eew_log2  = res_q.eew_log2;
  assign rsp_emul_log2 = res_q.emul_log2;

  AST_ILLEGAL_ZEROED: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_illegal) |-> (rsp_eew_log2 == '0 && rsp_emul_log2 == '0)); // R6

  AST_EMUL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_illegal) |-> (rsp_emul_log2 != 3'sb100)); // R4

  AST_EEW_WITHIN_ELEN: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_illegal) |-> (rsp_eew_log2 >= 4'd3 && rsp_eew_log2 <= ELEN_LIM)); // R2

  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (REGISTERED && rsp_valid && !rsp_ready) |-> !req_ready); // R7
endmodule

// File: tb/vmem_eew_chk_tb_top.sv
module vmem_eew_chk_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid;
  logic       req_ready;
  logic       req_mew;
  logic [2:0] req_width;
  logic [2:0] cfg_sew_log2;
  logic signed [2:0] cfg_lmul_log2;
  logic       cfg_vill;
  logic       rsp_valid;
  logic       rsp_ready;
  logic       rsp_illegal;
  logic [3:0] rsp_eew_log2;
  logic signed [2:0] rsp_emul_log2;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  vmem_eew_chk dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_mew(req_mew), .req_width(req_width),
    .cfg_sew_log2(cfg_sew_log2), .cfg_lmul_log2(cfg_lmul_log2), .cfg_vill(cfg_vill),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_illegal(rsp_illegal), .rsp_eew_log2(rsp_eew_log2), .rsp_emul_log2(rsp_emul_log2)
  );

  // {mew, width, sew_log2, lmul_log2, vill, exp_illegal, exp_eew_log2, exp_emul_log2}
  localparam int NV = 18;
  localparam logic [18:0] VEC [NV] = '{
    {1'b0, 3'd0, 3'd3, 3'd0, 1'b0, 1'b0, 4'd3, 3'd0},
    {1'b0, 3'd5, 3'd3, 3'd0, 1'b0, 1'b0, 4'd4, 3'd1},
    {1'b0, 3'd6, 3'd3, 3'd0, 1'b0, 1'b0, 4'd5, 3'd2},
    {1'b0, 3'd7, 3'd3, 3'd0, 1'b0, 1'b0, 4'd6, 3'd3},
    {1'b0, 3'd7, 3'd3, 3'd1, 1'b0, 1'b1, 4'd0, 3'd0},
    {1'b0, 3'd0, 3'd6, 3'd7, 1'b0, 1'b1, 4'd0, 3'd0},
    {1'b0, 3'd0, 3'd6, 3'd0, 1'b0, 1'b0, 4'd3, 3'd5},
    {1'b0, 3'd4, 3'd5, 3'd2, 1'b0, 1'b0, 4'd3, 3'd0},
    {1'b0, 3'd5, 3'd4, 3'd5, 1'b0, 1'b0, 4'd4, 3'd5},
    {1'b0, 3'd2, 3'd3, 3'd0, 1'b0, 1'b1, 4'd0, 3'd0},
    {1'b1, 3'd0, 3'd3, 3'd0, 1'b0, 1'b1, 4'd0, 3'd0},
    {1'b1, 3'd5, 3'd3, 3'd0, 1'b0, 1'b1, 4'd0, 3'd0},
    {1'b0, 3'd0, 3'd3, 3'd0, 1'b1, 1'b1, 4'd0, 3'd0},
    {1'b0, 3'd0, 3'd3, 3'd4, 1'b0, 1'b1, 4'd0, 3'd0},
    {1'b0, 3'd0, 3'd7, 3'd0, 1'b0, 1'b1, 4'd0, 3'd0},
    {1'b0, 3'd6, 3'd6, 3'd3, 1'b0, 1'b0, 4'd5, 3'd2},
    {1'b0, 3'd0, 3'd2, 3'd0, 1'b0, 1'b1, 4'd0, 3'd0},
    {1'b0, 3'd1, 3'd3, 3'd0, 1'b0, 1'b1, 4'd0, 3'd0}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp_v);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp_v);
    end
  endtask

  function automatic string ill_tag(input logic [18:0] v);
    if (v[8] || v[11:9] == 3'b100 || v[14:12] < 3'd3 || v[14:12] > 3'd6) return "R5";
    if (v[17:15] inside {3'd1, 3'd2, 3'd3}) return "R3";
    if (v[18]) return "R2";
    return "R4";
  endfunction

  task automatic drive(input logic [18:0] v);
    req_mew       = v[18];
    req_width     = v[17:15];
    cfg_sew_log2  = v[14:12];
    cfg_lmul_log2 = v[11:9];
    cfg_vill      = v[8];
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; rsp_ready = 1'b1;
    drive(VEC[0]);
    repeat (3) @(negedge clk);
    check(rsp_valid == 1'b0, "R8 rsp_valid in reset", int'(rsp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R8 rsp_valid after reset", int'(rsp_valid), 0);
    check(req_ready == 1'b1, "R8 req_ready after reset", int'(req_ready), 1);

    for (int i = 0; i < NV; i++) begin
      logic [18:0] v;
      int e_eew, e_emul, a_emul;
      v = VEC[i];
      drive(v);
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check(rsp_valid == 1'b1, "R7 result one edge later", int'(rsp_valid), 1);
      check(rsp_illegal == v[7], ill_tag(v), int'(rsp_illegal), int'(v[7]));
      e_eew  = int'(v[6:3]);
      e_emul = int'($signed(v[2:0]));
      a_emul = int'(rsp_emul_log2);
      if (v[7]) begin
        check(rsp_eew_log2 == 4'd0 && a_emul == 0, "R6 zeroed outputs",
              int'(rsp_eew_log2) + a_emul, 0);
      end else begin
        check(int'(rsp_eew_log2) == e_eew, v[18] ? "R2 eew" : "R1 eew", int'(rsp_eew_log2), e_eew);
        check(a_emul == e_emul, "R4 emul", a_emul, e_emul);
        check(int'(rsp_eew_log2) - a_emul == int'(v[14:12]) - int'($signed(v[11:9])),
              "R9 ratio", int'(rsp_eew_log2) - a_emul,
              int'(v[14:12]) - int'($signed(v[11:9])));
      end
      @(negedge clk);
    end

    // R7: back-pressure
    rsp_ready = 1'b0;
    drive(VEC[1]);
    req_valid = 1'b1;
    @(negedge clk);
    drive(VEC[3]);
    for (int k = 0; k < 3; k++) begin
      check(rsp_valid == 1'b1, "R7 held valid", int'(rsp_valid), 1);
      check(req_ready == 1'b0, "R7 input stalled", int'(req_ready), 0);
      check(rsp_eew_log2 == 4'd4 && rsp_emul_log2 == 3'sd1, "R7 held data",
            int'(rsp_eew_log2), 4);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    #1;
    check(req_ready == 1'b1, "R7 ready on drain", int'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid == 1'b1 && rsp_eew_log2 == 4'd6 && rsp_emul_log2 == 3'sd3,
          "R7 next result", int'(rsp_eew_log2), 6);
    @(negedge clk);
    check(rsp_valid == 1'b0, "R7 drained", int'(rsp_valid), 0);

    // R8: reset mid-stall
    rsp_ready = 1'b0;
    drive(VEC[0]);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R8 reset clears result", int'(rsp_valid), 0);
    check(req_ready == 1'b1, "R8 reset frees input", int'(req_ready), 1);
    rst_n = 1'b1;
    rsp_ready = 1'b1;
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule